// File: doc/BRIEF.md
# Triggered External-Clock Slave Counter

This block is a counter whose run enable is set by hardware rather than by software. While it is held in trigger mode, it watches one of several trigger lines. The first active edge on the selected line turns the counter on and raises a sticky trigger flag. From then on, the counter advances once for each rising edge of an asynchronous external clock pin. That pin is brought into the system clock domain by a two-flop synchronizer followed by an edge detector, so each counted edge lands a fixed three system clocks after the pin edge.

Software sets up the block through level-style configuration inputs:

- the slave mode;
- the trigger source;
- the trigger polarity.

Software can also load the count, stop the counter and clear the flag. A debug-freeze input halts counting. While the freeze is active, it also takes the output stage off the channel data. The output stage then either drives a programmed idle level or releases the pins to high impedance, as if the main output enable were low.

Top module: `trig_extclk_counter`

## Requirements
- R1: After reset, the count is 0, the run enable is 0, the trigger flag is 0, and `out_val` and `out_oe` are all zeros.
- R2: With `cfg_mode` = 3'b110 (trigger mode), an active edge on `trig_in[cfg_src]` sets `cnt_en` and `trig_flag` together. They appear at the third rising clock edge after the pin changes. Source code 3'd5 is the filtered channel-1 input, bit 5 of `trig_in`.
- R3: In any `cfg_mode` other than 3'b110, trigger edges set neither `cnt_en` nor `trig_flag`.
- R4: Edges on any `trig_in` bit other than the one `cfg_src` selects have no effect on `cnt_en` or `trig_flag`.
- R5: `cfg_pol` selects the trigger edge: 2'b00 means rising only, 2'b01 means falling only, 2'b11 means both edges, and 2'b10 behaves as 2'b00.
- R6: While `cnt_en` is 1, each rising edge of `ext_clk_in` adds one to `count`. The new value is visible after the third rising clock edge following the pin edge. Falling pin edges do not count, and no edge counts while `cnt_en` is 0.
- R7: The count is CNT_W bits wide. From all ones, it wraps to 0 on the next counted edge.
- R8: `trig_flag` stays at 1 until a cycle with `flag_clr` = 1 clears it. If a trigger edge and `flag_clr` fall in the same cycle, the flag is set. A trigger edge while `cnt_en` is already 1 sets the flag again and leaves `count` unchanged.
- R9: While `dbg_freeze` is 1, external clock edges are not counted. Counting resumes after `dbg_freeze` returns to 0.
- R10: The output stage is registered with one cycle of latency:
  - With `cfg_moe` = 1 and `dbg_freeze` = 0, `out_val` follows `oc_in` and `out_oe` is all ones.
  - Otherwise, with `cfg_off_idle` = 1, `out_val` equals `cfg_idle_lvl` and `out_oe` is all ones.
  - Otherwise, both are all zeros (high impedance).
- R11: A cycle with `cnt_wr` = 1 loads `cnt_wr_val` into `count` at the next clock edge. The load takes priority over a counted edge.
- R12: A cycle with `sw_stop` = 1 clears `cnt_en` at the next clock edge, and `sw_stop` wins over a trigger edge in that cycle. After that, external edges are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | TRIG_W | Asynchronous trigger lines |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| cfg_mode | input | 3 | Slave mode; 3'b110 is trigger mode |
| cfg_src | input | $clog2(TRIG_W) | Index of the trigger line in use |
| cfg_pol | input | 2 | Trigger polarity select |
| sw_stop | input | 1 | Software clear of the run enable |
| flag_clr | input | 1 | Software clear of the trigger flag |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wr_val | input | CNT_W | Value to load |
| dbg_freeze | input | 1 | Debug freeze: stop counting, output stage to off state |
| cfg_moe | input | 1 | Main output enable |
| cfg_off_idle | input | 1 | Off-state select: 1 drives the idle level, 0 gives high impedance |
| cfg_idle_lvl | input | OUT_W | Inactive level per output channel |
| oc_in | input | OUT_W | Channel data from the compare logic |
| count | output | CNT_W | Counter value |
| cnt_en | output | 1 | Run enable |
| trig_flag | output | 1 | Sticky trigger flag |
| out_val | output | OUT_W | Output pin values |
| out_oe | output | OUT_W | Output pin drive enables |

## Verification
The bench builds the block with its defaults: a 16-bit counter, eight trigger lines with a 3-bit source field, and two output channels. The counter is full width, so reaching 0xFFFF by counting pulses is out of reach. The wrap is therefore exercised by loading 0xFFFE through the count load port and then counting two edges. Eight trigger lines are enough for the source-select vectors to put an edge on an unselected line, as well as on the channel-1 line at index 5.

// File: rtl/tec_pkg.sv
package tec_pkg;

    localparam int unsigned MODE_W = 3;

    // Slave mode code that lets a trigger edge start the counter.
    localparam logic [MODE_W-1:0] MODE_TRIGGER = 3'b110;

    // Trigger polarity select codes.
    localparam logic [1:0] POL_RISE = 2'b00;
    localparam logic [1:0] POL_FALL = 2'b01;
    localparam logic [1:0] POL_BOTH = 2'b11;

endpackage

// File: rtl/tec_edge_sync.sv
module tec_edge_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
    assign prev_o = st_q.prev;

    // The previous-sample stage only ever copies the synchronized stage.
    assert_prev_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_o == $past(sync_o));

endmodule

// File: rtl/tec_slave_ctrl.sv
module tec_slave_ctrl
    import tec_pkg::*;
#(
    parameter int unsigned TRIG_W = 8,
    localparam int unsigned SRC_W = (TRIG_W > 1) ? $clog2(TRIG_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig_sync,
    input  logic [TRIG_W-1:0] trig_prev,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [1:0]        cfg_pol,
    input  logic              sw_stop,
    input  logic              flag_clr,
    output logic              en_o,
    output logic              flag_o
);

    typedef struct packed {
        logic en;
        logic flag;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  line_now, line_old, edge_r, edge_f, edge_hit, trig_hit;

    always_comb begin
        line_now = trig_sync[cfg_src];
        line_old = trig_prev[cfg_src];
        edge_r   = line_now & ~line_old;
        edge_f   = ~line_now & line_old;
        unique case (cfg_pol)
            POL_FALL: edge_hit = edge_f;
            POL_BOTH: edge_hit = edge_r | edge_f;
            default:  edge_hit = edge_r;
        endcase
        trig_hit = (cfg_mode == MODE_TRIGGER) && edge_hit;

        c_d = c_q;
        if (trig_hit) c_d.en = 1'b1;
        if (sw_stop)  c_d.en = 1'b0;
        if (flag_clr) c_d.flag = 1'b0;
        if (trig_hit) c_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign en_o   = c_q.en;
    assign flag_o = c_q.flag;

    assert_start_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> flag_o);

    assert_no_start_other_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != MODE_TRIGGER) |=> !(en_o && !$past(en_o)));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr) |=> flag_o);

    assert_stop_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stop |=> !en_o);

endmodule

// File: rtl/tec_counter.sv
module tec_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sync,
    input  logic             ext_prev,
    input  logic             run_en,
    input  logic             freeze,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic tick;

    always_comb begin
        tick = ext_sync & ~ext_prev & run_en & ~freeze;
        s_d  = s_q;
        if (wr)        s_d.cnt = wr_val;
        else if (tick) s_d.cnt = s_q.cnt + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

    assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr) |=> $stable(cnt_o));

    assert_hold_in_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr) |=> $stable(cnt_o));

    assert_step_or_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> (cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) + ONE)));

    assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt_o == $past(wr_val));

endmodule

// File: rtl/tec_out_stage.sv
module tec_out_stage #(
    parameter int unsigned OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             moe,
    input  logic             freeze,
    input  logic             off_idle,
    input  logic [OUT_W-1:0] idle_lvl,
    input  logic [OUT_W-1:0] data_in,
    output logic [OUT_W-1:0] pin_val,
    output logic [OUT_W-1:0] pin_oe
);

    typedef struct packed {
        logic [OUT_W-1:0] val;
        logic [OUT_W-1:0] oe;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (moe && !freeze) begin
            o_d.val = data_in;
            o_d.oe  = '1;
        end else if (off_idle) begin
            o_d.val = idle_lvl;
            o_d.oe  = '1;
        end else begin
            o_d.val = '0;
            o_d.oe  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pin_val = o_q.val;
    assign pin_oe  = o_q.oe;

    assert_release_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((!moe || freeze) && !off_idle) |=> (pin_oe == '0));

    assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((!moe || freeze) && off_idle) |=> (pin_val == $past(idle_lvl)));

    assert_pass_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (moe && !freeze) |=> (pin_val == $past(data_in)) && (pin_oe == '1));

endmodule

// File: rtl/trig_extclk_counter.sv
module trig_extclk_counter
    import tec_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned TRIG_W = 8,
    parameter int unsigned OUT_W  = 2,
    localparam int unsigned SRC_W = (TRIG_W > 1) ? $clog2(TRIG_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_W-1:0] trig_in,
    input  logic              ext_clk_in,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [1:0]        cfg_pol,
    input  logic              sw_stop,
    input  logic              flag_clr,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wr_val,
    input  logic              dbg_freeze,
    input  logic              cfg_moe,
    input  logic              cfg_off_idle,
    input  logic [OUT_W-1:0]  cfg_idle_lvl,
    input  logic [OUT_W-1:0]  oc_in,
    output logic [CNT_W-1:0]  count,
    output logic              cnt_en,
    output logic              trig_flag,
    output logic [OUT_W-1:0]  out_val,
    output logic [OUT_W-1:0]  out_oe
);

    logic [TRIG_W-1:0] trig_sync, trig_prev;
    logic              ext_sync, ext_prev;

    tec_edge_sync #(.W(TRIG_W)) u_trig_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .sync_o   (trig_sync),
        .prev_o   (trig_prev)
    );

    tec_edge_sync #(.W(1)) u_ext_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk_in),
        .sync_o   (ext_sync),
        .prev_o   (ext_prev)
    );

    tec_slave_ctrl #(.TRIG_W(TRIG_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_sync (trig_sync),
        .trig_prev (trig_prev),
        .cfg_mode  (cfg_mode),
        .cfg_src   (cfg_src),
        .cfg_pol   (cfg_pol),
        .sw_stop   (sw_stop),
        .flag_clr  (flag_clr),
        .en_o      (cnt_en),
        .flag_o    (trig_flag)
    );

    tec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_sync (ext_sync),
        .ext_prev (ext_prev),
        .run_en   (cnt_en),
        .freeze   (dbg_freeze),
        .wr       (cnt_wr),
        .wr_val   (cnt_wr_val),
        .cnt_o    (count)
    );

    tec_out_stage #(.OUT_W(OUT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .moe      (cfg_moe),
        .freeze   (dbg_freeze),
        .off_idle (cfg_off_idle),
        .idle_lvl (cfg_idle_lvl),
        .data_in  (oc_in),
        .pin_val  (out_val),
        .pin_oe   (out_oe)
    );

endmodule

// File: tb/trig_extclk_counter_bench.sv
module trig_extclk_counter_bench;

    localparam int CNT_W  = 16;
    localparam int TRIG_W = 8;
    localparam int OUT_W  = 2;
    localparam int SRC_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TRIG_W-1:0] trig_in = '0;
    logic              ext_clk_in = 1'b0;
    logic [2:0]        cfg_mode = 3'b000;
    logic [SRC_W-1:0]  cfg_src = '0;
    logic [1:0]        cfg_pol = 2'b00;
    logic              sw_stop = 1'b0;
    logic              flag_clr = 1'b0;
    logic              cnt_wr = 1'b0;
    logic [CNT_W-1:0]  cnt_wr_val = '0;
    logic              dbg_freeze = 1'b0;
    logic              cfg_moe = 1'b0;
    logic              cfg_off_idle = 1'b0;
    logic [OUT_W-1:0]  cfg_idle_lvl = '0;
    logic [OUT_W-1:0]  oc_in = '0;
    logic [CNT_W-1:0]  count;
    logic              cnt_en, trig_flag;
    logic [OUT_W-1:0]  out_val, out_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    trig_extclk_counter #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W)) u_trig_extclk_counter (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .ext_clk_in(ext_clk_in),
        .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_pol(cfg_pol),
        .sw_stop(sw_stop), .flag_clr(flag_clr), .cnt_wr(cnt_wr), .cnt_wr_val(cnt_wr_val),
        .dbg_freeze(dbg_freeze), .cfg_moe(cfg_moe), .cfg_off_idle(cfg_off_idle),
        .cfg_idle_lvl(cfg_idle_lvl), .oc_in(oc_in), .count(count), .cnt_en(cnt_en),
        .trig_flag(trig_flag), .out_val(out_val), .out_oe(out_oe)
    );

    // Vector fields: {mode[11:9], src[8:6], pol[5:4], line[3:1], expect_start[0]}
    localparam logic [11:0] VEC [0:7] = '{
        {3'b110, 3'd5, 2'b00, 3'd5, 1'b1},  // R2 channel-1 rising
        {3'b110, 3'd5, 2'b00, 3'd3, 1'b0},  // R4 unselected line
        {3'b000, 3'd5, 2'b00, 3'd5, 1'b0},  // R3 mode off
        {3'b110, 3'd2, 2'b00, 3'd2, 1'b1},  // R2 other source
        {3'b110, 3'd5, 2'b01, 3'd5, 1'b1},  // R5 falling
        {3'b111, 3'd5, 2'b00, 3'd5, 1'b0},  // R3 other mode
        {3'b110, 3'd7, 2'b11, 3'd7, 1'b1},  // R5 both edges
        {3'b110, 3'd5, 2'b10, 3'd5, 1'b1}   // R5 reserved acts as rising
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_state();
        @(negedge clk); sw_stop = 1'b1; flag_clr = 1'b1;
        @(negedge clk); sw_stop = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic trig_pulse(input int line);
        @(negedge clk); trig_in[line] = 1'b1;
        repeat (4) @(negedge clk);
        trig_in[line] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_clk_in = 1'b1;
        repeat (4) @(negedge clk);
        ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 cnt_en", 32'(cnt_en), 0);
        chk("R1 trig_flag", 32'(trig_flag), 0);
        chk("R1 out_oe", 32'(out_oe), 0);
        chk("R1 out_val", 32'(out_val), 0);

        // Trigger decode vectors
        for (int i = 0; i < 8; i++) begin
            idle_state();
            @(negedge clk);
            cfg_mode = VEC[i][11:9];
            cfg_src  = VEC[i][8:6];
            cfg_pol  = VEC[i][5:4];
            trig_pulse(int'(VEC[i][3:1]));
            chk("R2/R3/R4/R5 vector cnt_en", 32'(cnt_en), 32'(VEC[i][0]));
            chk("R2/R3/R4/R5 vector trig_flag", 32'(trig_flag), 32'(VEC[i][0]));
        end
        chk("R6 count untouched by triggers", 32'(count), 0);

        // R5 falling polarity must ignore the rising edge
        idle_state();
        @(negedge clk); cfg_mode = 3'b110; cfg_src = 3'd5; cfg_pol = 2'b01;
        trig_in[5] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 falling ignores rise", 32'(cnt_en), 0);
        trig_in[5] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 falling starts", 32'(cnt_en), 1);

        // R2 latency: set at third edge after the pin change
        idle_state();
        @(negedge clk); cfg_pol = 2'b00; trig_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 not before third edge", 32'(cnt_en), 0);
        @(negedge clk);
        chk("R2 cnt_en at third edge", 32'(cnt_en), 1);
        chk("R2 trig_flag at third edge", 32'(trig_flag), 1);
        trig_in[5] = 1'b0;
        repeat (4) @(negedge clk);

        // R6 no counting while stopped
        idle_state();
        ext_pulse(); ext_pulse();
        chk("R6 no count while stopped", 32'(count), 0);
        trig_pulse(5);
        // R6 latency of a counted edge
        @(negedge clk); ext_clk_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R6 count not before third edge", 32'(count), 0);
        @(negedge clk);
        chk("R6 count at third edge", 32'(count), 1);
        ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 falling edge not counted", 32'(count), 1);
        for (int k = 0; k < 4; k++) ext_pulse();
        chk("R6 five edges counted", 32'(count), 5);

        // R8 flag sticky, clear, retrigger while running
        chk("R8 flag still set", 32'(trig_flag), 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R8 flag cleared", 32'(trig_flag), 0);
        trig_pulse(5);
        chk("R8 retrigger sets flag", 32'(trig_flag), 1);
        chk("R8 retrigger keeps count", 32'(count), 5);

        // R9 debug freeze
        @(negedge clk); dbg_freeze = 1'b1;
        ext_pulse(); ext_pulse(); ext_pulse();
        chk("R9 frozen count", 32'(count), 5);
        @(negedge clk); dbg_freeze = 1'b0;
        ext_pulse();
        chk("R9 resumes", 32'(count), 6);

        // R11 load and R7 wrap
        @(negedge clk); cnt_wr = 1'b1; cnt_wr_val = 16'hFFFE;
        @(negedge clk); cnt_wr = 1'b0;
        chk("R11 load", 32'(count), 32'hFFFE);
        ext_pulse();
        chk("R7 reaches all ones", 32'(count), 32'hFFFF);
        ext_pulse();
        chk("R7 wraps to zero", 32'(count), 0);

        // R12 software stop
        @(negedge clk); sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
        chk("R12 enable cleared", 32'(cnt_en), 0);
        ext_pulse();
        chk("R12 no count after stop", 32'(count), 0);

        // R10 output stage
        @(negedge clk); cfg_moe = 1'b1; oc_in = 2'b10; cfg_idle_lvl = 2'b01;
        @(negedge clk);
        chk("R10 pass value", 32'(out_val), 32'h2);
        chk("R10 pass enable", 32'(out_oe), 32'h3);
        dbg_freeze = 1'b1; cfg_off_idle = 1'b1;
        @(negedge clk);
        chk("R10 freeze idle value", 32'(out_val), 32'h1);
        chk("R10 freeze idle enable", 32'(out_oe), 32'h3);
        cfg_off_idle = 1'b0;
        @(negedge clk);
        chk("R10 freeze hiz enable", 32'(out_oe), 0);
        chk("R10 freeze hiz value", 32'(out_val), 0);
        dbg_freeze = 1'b0; cfg_moe = 1'b0; cfg_off_idle = 1'b1;
        @(negedge clk);
        chk("R10 moe off idle", 32'(out_val), 32'h1);
        cfg_off_idle = 1'b0;
        @(negedge clk);
        chk("R10 moe off hiz", 32'(out_oe), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule